// File: doc/BRIEF.md
# Multi-Cycle Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point numbers. Each word has a sign in bit 31 (0 means non-negative), an 8-bit exponent in bits 30:23 stored with an offset of 127, and a 23-bit fraction in bits 22:0. A normal value carries an implied leading 1 above its fraction. Exponent code 0 means zero, and exponent code 255 means infinity or not-a-number. Normal exponents run from 1 to 254.

A caller presents both operands and the add/subtract select, then pulses `start` for one cycle. The work is split into one stage per clock: first the operand with the smaller magnitude is shifted right to line up with the larger one, then the two significands are summed, then the sum is normalized, and finally it is rounded to nearest-even and renormalized. A one-cycle `done` pulse marks a new packed result and its two exception flags. These outputs are registered and hold their values until the next operation completes.

Three extra bits travel below the 24-bit significand: guard, round and sticky. Every bit shifted past the sticky position during alignment is ORed into it, so rounding sees whether any discarded value was nonzero.

Top module: `fp32_addsub_mc`

## Requirements
- R1: For two normal operands whose result is in range, `result` is the exact sum, rounded to 24 significant bits with round-to-nearest, ties to even. It is packed as sign bit 31, exponent bits 30:23 with offset 127, and fraction bits 22:0.
- R2: When `sub_sel` is 1, the sign of `op_b` is inverted before alignment, so the result is `op_a - op_b`. When `sub_sel` is 0 the result is `op_a + op_b`.
- R3: Bits lost while aligning the smaller operand still count in rounding. An exact halfway case rounds to the even fraction, and anything above halfway rounds up.
- R4: When rounding carries out of the significand, the fraction becomes 0 and the exponent grows by one.
- R5: A finite result whose rounded exponent reaches 255 or more becomes infinity with the result's sign (exponent 0xFF, fraction 0), and `ovf_flag` is 1.
- R6: A nonzero result whose rounded exponent falls below 1 becomes zero with the result's sign (bits 30:0 all 0), and `unf_flag` is 1. `ovf_flag` and `unf_flag` are never both 1.
- R7: A result that is exactly zero is packed as 0x00000000 (+0), with both flags 0.
- R8: An operand with exponent code 0 is treated as zero, whatever its fraction is.
- R9: An operand with exponent 0xFF and a nonzero fraction gives 0x7FC00000. So does the sum of infinities of opposite effective sign. Otherwise an infinite operand gives that infinity with its effective sign. Both flags are 0 in all these cases.
- R10: `done` is a single-cycle pulse that rises on the fourth clock edge after the edge that samples `start`. A `start` seen while an operation is in progress is ignored.
- R11: While `rst` is high, `result`, `done`, `ovf_flag` and `unf_flag` are all 0 from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request that captures the operands |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub_sel | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b |
| result | output | 32 | Packed sum or difference |
| done | output | 1 | One-cycle pulse when result and flags update |
| ovf_flag | output | 1 | Result overflowed to infinity |
| unf_flag | output | 1 | Result underflowed to signed zero |

## Verification
Operands with nearly equal exponents and opposite effective signs cause heavy cancellation, which tests the left-shift normalizer. Exponent gaps of up to about thirty test alignment and the sticky bit. Fully random words add zeros, denormals, infinities and not-a-number codes, which test the special-case path. Chosen halfway, just-above-halfway and all-ones-fraction cases separate ties-to-even from plain round-up, and show the renormalize step. Operands at the top and bottom of the exponent range are used to trigger the two flags.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  parameter int EXP_W  = 8;
  parameter int MAN_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + MAN_W;
  localparam int SIG_W   = MAN_W + 1;
  localparam int GRS_W   = 3;
  localparam int EXT_W   = SIG_W + GRS_W;
  localparam int SUM_W   = EXT_W + 1;
  localparam int SEXP_W  = EXP_W + 2;
  localparam int LZ_W    = $clog2(EXT_W) + 1;
  localparam int EXP_TOP = (1 << EXP_W) - 1;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
    logic             zero;
    logic             inf;
    logic             nan;
  } fp_unp_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ADD,
    ST_NORM,
    ST_ROUND
  } stage_e;

  function automatic logic [WORD_W-1:0] quiet_nan();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] signed_inf(input logic s);
    return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  endfunction
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
  import fpadd_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              neg_i,
  output fp_unp_t           unp_o
);
  logic [EXP_W-1:0] e_fld;
  logic [MAN_W-1:0] f_fld;

  always_comb begin
    e_fld      = word_i[WORD_W-2:MAN_W];
    f_fld      = word_i[MAN_W-1:0];
    unp_o.sign = word_i[WORD_W-1] ^ neg_i;
    unp_o.zero = (e_fld == '0);
    unp_o.inf  = (e_fld == '1) && (f_fld == '0);
    unp_o.nan  = (e_fld == '1) && (f_fld != '0);
    unp_o.exp  = unp_o.zero ? '0 : e_fld;
    unp_o.sig  = unp_o.zero ? '0 : {1'b1, f_fld};
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
(
  input  fp_unp_t           a_i,
  input  fp_unp_t           b_i,
  output logic [EXT_W-1:0]  big_o,
  output logic [EXT_W-1:0]  small_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              sign_o,
  output logic              sub_o
);
  fp_unp_t          hi, lo;
  logic             a_ge;
  logic [EXP_W-1:0] diff, dsat;
  logic [EXT_W-1:0] lo_ext, kept, lost;

  always_comb begin
    a_ge    = {a_i.exp, a_i.sig} >= {b_i.exp, b_i.sig};
    hi      = a_ge ? a_i : b_i;
    lo      = a_ge ? b_i : a_i;
    diff    = hi.exp - lo.exp;
    dsat    = (diff > EXP_W'(EXT_W)) ? EXP_W'(EXT_W) : diff;
    lo_ext  = {lo.sig, {GRS_W{1'b0}}};
    kept    = lo_ext >> dsat;
    lost    = lo_ext & ~({EXT_W{1'b1}} << dsat);
    small_o = kept | {{(EXT_W-1){1'b0}}, |lost};
    big_o   = {hi.sig, {GRS_W{1'b0}}};
    exp_o   = hi.exp;
    sign_o  = hi.sign;
    sub_o   = a_i.sign ^ b_i.sign;
  end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
(
  input  logic [SUM_W-1:0]         sum_i,
  input  logic [EXP_W-1:0]         exp_i,
  output logic [EXT_W-1:0]         nm_o,
  output logic signed [SEXP_W-1:0] exp_o,
  output logic                     zero_o
);
  logic [LZ_W-1:0] lz;

  always_comb begin
    lz = '0;
    for (int i = 0; i < EXT_W; i++) begin
      if (sum_i[i]) lz = LZ_W'(EXT_W - 1 - i);
    end
    zero_o = (sum_i == '0);
    if (sum_i[SUM_W-1]) begin
      nm_o  = {sum_i[SUM_W-1:2], sum_i[1] | sum_i[0]};
      exp_o = $signed(SEXP_W'(exp_i)) + $signed(SEXP_W'(1));
    end else begin
      nm_o  = sum_i[EXT_W-1:0] << lz;
      exp_o = $signed(SEXP_W'(exp_i)) - $signed(SEXP_W'(lz));
    end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic [EXT_W-1:0]         nm_i,
  input  logic signed [SEXP_W-1:0] exp_i,
  input  logic                     zero_i,
  input  logic                     sign_i,
  output logic [WORD_W-1:0]        word_o,
  output logic                     ovf_o,
  output logic                     unf_o
);
  logic                     bump;
  logic [SIG_W:0]           rsum;
  logic [MAN_W-1:0]         frac;
  logic signed [SEXP_W-1:0] efin;

  always_comb begin
    bump = nm_i[GRS_W-1] & (nm_i[GRS_W] | (|nm_i[GRS_W-2:0]));
    rsum = {1'b0, nm_i[EXT_W-1:GRS_W]} + (SIG_W+1)'(bump);
    frac = rsum[SIG_W] ? rsum[SIG_W-1:1] : rsum[MAN_W-1:0];
    efin = exp_i + (rsum[SIG_W] ? $signed(SEXP_W'(1)) : $signed(SEXP_W'(0)));
    ovf_o = 1'b0;
    unf_o = 1'b0;
    if (zero_i) begin
      word_o = '0;
    end else if (efin >= $signed(SEXP_W'(EXP_TOP))) begin
      word_o = signed_inf(sign_i);
      ovf_o  = 1'b1;
    end else if (efin < $signed(SEXP_W'(1))) begin
      word_o = {sign_i, {(WORD_W-1){1'b0}}};
      unf_o  = 1'b1;
    end else begin
      word_o = {sign_i, efin[EXP_W-1:0], frac};
    end
  end
endmodule

// File: rtl/fp32_addsub_mc.sv
module fp32_addsub_mc
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              sub_sel,
  output logic [WORD_W-1:0] result,
  output logic              done,
  output logic              ovf_flag,
  output logic              unf_flag
);
  stage_e st;

  // operand decode, one unpacker per input word
  logic [WORD_W-1:0] in_word [2];
  logic              in_neg  [2];
  fp_unp_t           unp     [2];

  assign in_word[0] = op_a;
  assign in_word[1] = op_b;
  assign in_neg[0]  = 1'b0;
  assign in_neg[1]  = sub_sel;

  for (genvar gi = 0; gi < 2; gi++) begin : g_unp
    fpadd_unpack u_unp (.word_i(in_word[gi]), .neg_i(in_neg[gi]), .unp_o(unp[gi]));
  end

  // special operands bypass the datapath
  logic              spec_c;
  logic [WORD_W-1:0] spec_val_c;

  always_comb begin
    spec_c = unp[0].nan | unp[1].nan | unp[0].inf | unp[1].inf;
    if (unp[0].nan || unp[1].nan ||
        (unp[0].inf && unp[1].inf && (unp[0].sign != unp[1].sign)))
      spec_val_c = quiet_nan();
    else if (unp[0].inf)
      spec_val_c = signed_inf(unp[0].sign);
    else
      spec_val_c = signed_inf(unp[1].sign);
  end

  // stage registers
  fp_unp_t                  opa_q, opb_q;
  logic                     spec_q;
  logic [WORD_W-1:0]        spec_val_q;
  logic [EXT_W-1:0]         big_q, small_q;
  logic [EXP_W-1:0]         ebig_q;
  logic                     sgn_q, sub_q;
  logic [SUM_W-1:0]         sum_q;
  logic [EXT_W-1:0]         nm_q;
  logic signed [SEXP_W-1:0] en_q;
  logic                     nz_q;

  logic [EXT_W-1:0]         al_big, al_small;
  logic [EXP_W-1:0]         al_exp;
  logic                     al_sign, al_sub;
  logic [EXT_W-1:0]         nr_nm;
  logic signed [SEXP_W-1:0] nr_exp;
  logic                     nr_zero;
  logic [WORD_W-1:0]        rd_word;
  logic                     rd_ovf, rd_unf;

  fpadd_align u_align (
    .a_i(opa_q), .b_i(opb_q), .big_o(al_big), .small_o(al_small),
    .exp_o(al_exp), .sign_o(al_sign), .sub_o(al_sub)
  );

  fpadd_norm u_norm (
    .sum_i(sum_q), .exp_i(ebig_q), .nm_o(nr_nm), .exp_o(nr_exp), .zero_o(nr_zero)
  );

  fpadd_round u_round (
    .nm_i(nm_q), .exp_i(en_q), .zero_i(nz_q), .sign_i(sgn_q),
    .word_o(rd_word), .ovf_o(rd_ovf), .unf_o(rd_unf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      done     <= 1'b0;
      result   <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          opa_q      <= unp[0];
          opb_q      <= unp[1];
          spec_q     <= spec_c;
          spec_val_q <= spec_val_c;
          st         <= ST_ALIGN;
        end
        ST_ALIGN: begin
          big_q   <= al_big;
          small_q <= al_small;
          ebig_q  <= al_exp;
          sgn_q   <= al_sign;
          sub_q   <= al_sub;
          st      <= ST_ADD;
        end
        ST_ADD: begin
          sum_q <= sub_q ? ({1'b0, big_q} - {1'b0, small_q})
                         : ({1'b0, big_q} + {1'b0, small_q});
          st    <= ST_NORM;
        end
        ST_NORM: begin
          nm_q <= nr_nm;
          en_q <= nr_exp;
          nz_q <= nr_zero;
          st   <= ST_ROUND;
        end
        ST_ROUND: begin
          result   <= spec_q ? spec_val_q : rd_word;
          ovf_flag <= !spec_q && rd_ovf;
          unf_flag <= !spec_q && rd_unf;
          done     <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: completion is a single pulse issued only out of the rounding stage
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_from_round: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(st) == ST_ROUND);

  // R3: alignment leaves the smaller operand no larger than the bigger one
  a_r3_align_order: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADD) |-> (small_q <= big_q));

  // R4: the normalizer hands a leading one to the rounder
  a_r4_norm_lead: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ROUND && !nz_q) |-> nm_q[EXT_W-1]);

  // R5: overflow flag goes with an infinity
  a_r5_ovf_inf: assert property (@(posedge clk) disable iff (rst)
    (done && ovf_flag) |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}}));

  // R6: underflow flag goes with a signed zero, never with overflow
  a_r6_unf_zero: assert property (@(posedge clk) disable iff (rst)
    (done && unf_flag) |-> (result[WORD_W-2:0] == '0));
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ovf_flag && unf_flag));
endmodule

// File: tb/fp32_addsub_mc_test.sv
module fp32_addsub_mc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        in_sub = 1'b0;
  logic [31:0] result;
  logic        done, ovf_flag, unf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] g_res;
  logic        g_ovf, g_unf;
  int          g_lat;

  fp32_addsub_mc uut (
    .clk(clk), .rst(rst), .start(start), .op_a(in_a), .op_b(in_b),
    .sub_sel(in_sub), .result(result), .done(done),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got ovf=%0b unf=%0b word=%08h, expected ovf=%0b unf=%0b word=%08h",
               tag, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic check_int(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d, expected %0d", tag, got, exp);
    end
  endtask

  function automatic real w2r(input logic [31:0] w);
    real m;
    int  e;
    e = int'(w[30:23]);
    if (e == 0) return 0.0;
    m = 1.0 + real'(int'(w[22:0])) / 8388608.0;
    for (int i = 0; i < e - 127; i++) m = m * 2.0;
    for (int i = 0; i < 127 - e; i++) m = m / 2.0;
    return w[31] ? -m : m;
  endfunction

  // expected {ovf, unf, word} from the requirements, using a wide exact sum
  function automatic logic [33:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic        sa, sb, za, zb, ia, ib, na, nb, bs, st, up;
    int          ea, eb, be, se, d, t, e;
    logic [23:0] ma, mb, bm, sm;
    logic [63:0] big, full, part, sum, kept, rem, half;
    sa = a[31]; sb = b[31] ^ s;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    za = (ea == 0); zb = (eb == 0);
    ia = (ea == 255) && (a[22:0] == 0); na = (ea == 255) && (a[22:0] != 0);
    ib = (eb == 255) && (b[22:0] == 0); nb = (eb == 255) && (b[22:0] != 0);
    if (na || nb || (ia && ib && sa != sb)) return {2'b00, 32'h7FC00000};
    if (ia) return {2'b00, sa, 8'hFF, 23'd0};
    if (ib) return {2'b00, sb, 8'hFF, 23'd0};
    ma = za ? 24'd0 : {1'b1, a[22:0]}; if (za) ea = 0;
    mb = zb ? 24'd0 : {1'b1, b[22:0]}; if (zb) eb = 0;
    if ((ea > eb) || (ea == eb && ma >= mb)) begin
      be = ea; bm = ma; bs = sa; se = eb; sm = mb;
    end else begin
      be = eb; bm = mb; bs = sb; se = ea; sm = ma;
    end
    d    = be - se;
    big  = 64'(bm) << 38;
    full = 64'(sm) << 38;
    if (d >= 62) begin part = 0; st = (sm != 0); end
    else begin part = full >> d; st = ((full & ((64'd1 << d) - 1)) != 0); end
    if (sa == sb) sum = big + part;
    else sum = st ? (big - part - 1) : (big - part);
    if (sum == 0 && !st) return 34'd0;
    t = 0;
    for (int i = 0; i < 64; i++) if (sum[i]) t = i;
    e = be + t - 61;
    if (t >= 24) begin
      kept = sum >> (t - 23);
      rem  = sum & ((64'd1 << (t - 23)) - 1);
      half = 64'd1 << (t - 24);
      up   = (rem > half) || (rem == half && (st || kept[0]));
    end else begin
      kept = sum << (23 - t);
      up   = 1'b0;
    end
    kept = kept + 64'(up);
    if (kept[24]) begin kept = kept >> 1; e = e + 1; end
    if (e >= 255) return {2'b10, bs, 8'hFF, 23'd0};
    if (e < 1) return {2'b01, bs, 31'd0};
    return {2'b00, bs, 8'(e), kept[22:0]};
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s);
    @(negedge clk);
    in_a = a; in_b = b; in_sub = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    g_lat = 1;
    while (!done && g_lat < 40) begin
      @(negedge clk);
      g_lat++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10: no done pulse, got latency %0d, expected 5", g_lat);
    end
    g_res = result; g_ovf = ovf_flag; g_unf = unf_flag;
  endtask

  task automatic directed(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic s, input logic [33:0] exp);
    run_op(a, b, s);
    check(tag, {g_ovf, g_unf, g_res}, exp);
    check(tag, {g_ovf, g_unf, g_res}, ref_add(a, b, s));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] ra, rb;
    logic        rs;
    int          ea, eb, mode;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {ovf_flag, unf_flag, result}, 34'd0);
    check_int("R11", int'(done), 0);
    rst = 1'b0;

    // R1: 0.5 + (-0.4375) = 0.0625
    directed("R1", 32'h3F000000, 32'hBEE00000, 1'b0, {2'b00, 32'h3D800000});
    // R10: latency of four edges after the sampling edge
    check_int("R10", g_lat, 5);
    // R8/R1: -5.0 plus zero returns -5.0
    directed("R8", 32'hC0A00000, 32'h00000000, 1'b0, {2'b00, 32'hC0A00000});
    n_chk++;
    if (w2r(g_res) != -5.0) begin
      n_bad++;
      $display("FAIL R1: got %f, expected -5.0", w2r(g_res));
    end
    // R2: subtraction 3.0 - 1.0
    directed("R2", 32'h40400000, 32'h3F800000, 1'b1, {2'b00, 32'h40000000});
    directed("R2", 32'h40400000, 32'h3F800000, 1'b0, {2'b00, 32'h40800000});
    // R3: ties to even, above-half rounds up
    directed("R3", 32'h3F800000, 32'h33800000, 1'b0, {2'b00, 32'h3F800000});
    directed("R3", 32'h3F800001, 32'h33800000, 1'b0, {2'b00, 32'h3F800002});
    directed("R3", 32'h3F800000, 32'h33800001, 1'b0, {2'b00, 32'h3F800001});
    // R4: rounding carry renormalizes
    directed("R4", 32'h3FFFFFFF, 32'h33800000, 1'b0, {2'b00, 32'h40000000});
    // R5: overflow to signed infinity
    directed("R5", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, {2'b10, 32'h7F800000});
    directed("R5", 32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, {2'b10, 32'hFF800000});
    // R6: underflow to signed zero
    directed("R6", 32'h00800000, 32'h00C00000, 1'b1, {2'b01, 32'h80000000});
    // R7: exact cancellation gives +0
    directed("R7", 32'h40490FDB, 32'h40490FDB, 1'b1, 34'd0);
    directed("R7", 32'hC0000000, 32'h40000000, 1'b0, 34'd0);
    // R8: denormal operands act as zero
    directed("R8", 32'h3F800000, 32'h00000001, 1'b0, {2'b00, 32'h3F800000});
    directed("R8", 32'h00400000, 32'h00400000, 1'b0, 34'd0);
    // R9: infinity and not-a-number
    directed("R9", 32'h7F800000, 32'h3F800000, 1'b0, {2'b00, 32'h7F800000});
    directed("R9", 32'h7F800000, 32'h7F800000, 1'b1, {2'b00, 32'h7FC00000});
    directed("R9", 32'h3F800000, 32'h7F800000, 1'b1, {2'b00, 32'hFF800000});
    directed("R9", 32'h7F800001, 32'h3F800000, 1'b0, {2'b00, 32'h7FC00000});

    // R10: start while busy is ignored, result holds afterwards
    @(negedge clk);
    in_a = 32'h3F800000; in_b = 32'h40000000; in_sub = 1'b0; start = 1'b1;
    @(negedge clk);
    in_a = 32'h42000000; in_b = 32'h42000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R10", {ovf_flag, unf_flag, result}, {2'b00, 32'h40400000});
    begin
      int extra = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check_int("R10", extra, 0);
      check("R10", {ovf_flag, unf_flag, result}, {2'b00, 32'h40400000});
    end

    // R1: constrained random against the exact reference and a real-number sum
    for (int k = 0; k < 600; k++) begin
      mode = int'($urandom % 4);
      ra = $urandom; rb = $urandom; rs = 1'($urandom);
      if (mode != 0) begin
        ea = 1 + int'($urandom % 254);
        if (mode == 1) eb = ea + int'($urandom % 7) - 3;
        else if (mode == 2) eb = ea + int'($urandom % 61) - 30;
        else begin
          ea = ($urandom % 2 == 0) ? 254 - int'($urandom % 3) : 1 + int'($urandom % 3);
          eb = ea + int'($urandom % 5) - 2;
        end
        if (eb < 1) eb = 1;
        if (eb > 254) eb = 254;
        ra[30:23] = 8'(ea); rb[30:23] = 8'(eb);
      end
      run_op(ra, rb, rs);
      check("R1", {g_ovf, g_unf, g_res}, ref_add(ra, rb, rs));
      if (mode != 0 && !g_ovf && !g_unf && g_res[30:23] != 8'h00) begin
        real want, got, err;
        want = w2r(ra) + (rs ? -w2r(rb) : w2r(rb));
        got  = w2r(g_res);
        err  = (got > want) ? got - want : want - got;
        n_chk++;
        if (err > ((got < 0.0) ? -got : got) / 8388608.0) begin
          n_bad++;
          $display("FAIL R1: got %e, expected %e", got, want);
        end
      end
    end
    finish_run();
  end
endmodule